// File: doc/BRIEF.md
# Oversampled Serial Receiver with Maskable Error Interrupt

This block receives asynchronous serial characters on a single line and places each completed character in a receive data register. The line is oversampled 16 times per bit, pacing being given by an external oversample tick. Three samples are taken around the centre of every bit, and the majority value becomes the bit. A frame is one start bit, eight data bits sent least significant bit first, an optional parity bit (odd or even), and one stop bit.

Four error conditions are tracked as sticky flags: overrun, noise, framing and parity. Each flag has its own enable. The enabled flags are ORed into one error interrupt request. Software clears flags in two steps: it reads the status, then it reads the data. While a debug halt is active, clearing is suppressed unless a permission input allows it. A stop input models the loss of the module clock: any frame in progress is dropped and the receiver returns to idle.

Top module: `serial_rx_errirq`

## Requirements
- R1: A frame is a start bit (0), 8 data bits sent LSB first, an optional parity bit and a stop bit. Each bit lasts 16 oversample ticks, counted from the tick that first sees the line low after it was high (tick 0). The bit value is the majority of the samples at ticks 7, 8 and 9. At the stop bit's tick 9 the character goes to `rx_data_o` and `rx_full_o` is set. Both outputs change on the second clock edge after that tick. After reset the data is 0 and all flags are 0.
- R2: If the majority of the start bit samples is 1, the frame is rejected as a false start. No character is delivered, no flag is set, and the receiver waits for a new falling edge.
- R3: `err_flags_o[1]` (noise) is set when the three samples of any bit disagree. This covers the start bit, the data bits, the parity bit and the stop bit.
- R4: `err_flags_o[2]` (framing) is set when the stop bit majority is 0. The character is still delivered, and this includes an all-zero break character.
- R5: When `par_en_i` is 1, the bit after the data is parity. `err_flags_o[3]` (parity) is set when the XOR of the 8 data bits and the parity bit differs from `par_odd_i` (0 = even, 1 = odd).
- R6: If a character completes while `rx_full_o` is 1, `err_flags_o[0]` (overrun) is set. The old data is kept, `rx_full_o` stays 1, and the errors of the lost character are discarded.
- R7: `err_irq_o` is 1 exactly when some bit i has both `err_flags_o[i]` and `err_ien_i[i]` set. The enable bit positions match the flag positions.
- R8: A `stat_rd_i` pulse records the flags that are set at that moment. A later `data_rd_i` pulse clears those recorded flags and clears `rx_full_o`. A data read with no status read before it clears only `rx_full_o`.
- R9: While `dbg_halt_i` is 1 and `halt_clr_ok_i` is 0, a data read clears neither the flags nor `rx_full_o`, and the recorded flags are kept. With `halt_clr_ok_i` at 1, clearing works as in R8.
- R10: While `rx_stop_i` is 1, the receiver is forced to idle and any partial frame is abandoned. After `rx_stop_i` falls, the next complete frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_line_i | input | 1 | Asynchronous serial line, idle high |
| os_tick_i | input | 1 | Oversample tick, one clock wide, 16 per bit |
| rx_stop_i | input | 1 | Module clock stopped; abandon any frame |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even |
| err_ien_i | input | 4 | Per-flag interrupt enables (0 overrun, 1 noise, 2 framing, 3 parity) |
| stat_rd_i | input | 1 | Status read strobe |
| data_rd_i | input | 1 | Data read strobe |
| dbg_halt_i | input | 1 | Debug halt state active |
| halt_clr_ok_i | input | 1 | Allow flag clearing during debug halt |
| rx_data_o | output | 8 | Receive data register |
| err_flags_o | output | 4 | Error flags (0 overrun, 1 noise, 2 framing, 3 parity) |
| rx_full_o | output | 1 | Receive data register holds an unread character |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
A character's data, full flag and error flags are due on the second clock edge after the oversample tick that carries the stop bit's third sample. The first edge loads the bit engine's output register and the second loads the status register. Read strobes act on the next edge, and the interrupt follows the flags in the same cycle. The bench changes the line three cycles before each tick, which covers the two-stage synchronizer. Its model applies a pending character one step after the stop tick and applies read effects in the step that drives the strobe, so the comparison made at every falling clock edge sees each result in exactly the cycle it is due.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP
   } rx_state_e;

   // error flag bit positions, shared by flags and enables
   localparam int unsigned ERR_OVR   = 0;
   localparam int unsigned ERR_NOISE = 1;
   localparam int unsigned ERR_FRAME = 2;
   localparam int unsigned ERR_PAR   = 3;
   localparam int unsigned N_ERR     = 4;

   typedef struct packed {
      logic noise;
      logic frame;
      logic par;
   } frame_err_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 1) begin : g_bad_stages
      $error("rx_line_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic q_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) q_q <= RST_VAL;
         else         q_q <= d_i;
      end
      assign q_o = q_q;
   end else begin : g_chain
      logic [STAGES-1:0] sr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
         else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
      assign q_o = sr_q[STAGES-1];
   end

endmodule

// File: rtl/rx_vote3.sv
module rx_vote3 (
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   output logic maj_o,
   output logic dis_o
);

   assign maj_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
   assign dis_o = (a_i ^ b_i) | (b_i ^ c_i);

endmodule

// File: rtl/rx_bit_engine.sv
module rx_bit_engine
   import serial_rx_pkg::*;
#(
   parameter int unsigned OSR       = 16,
   parameter int unsigned DATA_BITS = 8
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 line_i,
   input  logic                 tick_i,
   input  logic                 halt_i,
   input  logic                 par_en_i,
   input  logic                 par_odd_i,
   output logic                 done_o,
   output logic [DATA_BITS-1:0] data_o,
   output frame_err_t           errs_o
);

   localparam int unsigned CW = $clog2(OSR);
   localparam int unsigned IW = $clog2(DATA_BITS);
   localparam logic [CW-1:0] SMP0 = CW'(OSR / 2 - 1);
   localparam logic [CW-1:0] SMP1 = CW'(OSR / 2);
   localparam logic [CW-1:0] SMP2 = CW'(OSR / 2 + 1);
   localparam logic [CW-1:0] LAST = CW'(OSR - 1);
   localparam logic [IW-1:0] BIT_LAST = IW'(DATA_BITS - 1);

   if (OSR < 4) begin : g_bad_osr
      $error("rx_bit_engine: OSR must be at least 4");
   end
   if (DATA_BITS < 5 || DATA_BITS > 9) begin : g_bad_bits
      $error("rx_bit_engine: DATA_BITS must be 5..9");
   end

   rx_state_e            state_q;
   logic [CW-1:0]        cnt_q;
   logic [IW-1:0]        bit_idx_q;
   logic [DATA_BITS-1:0] sh_q;
   logic                 s_a_q, s_b_q;
   logic                 noise_q;
   logic                 par_bit_q;
   logic                 last_q;
   logic                 vote, dis;
   logic                 at_vote, at_last;

   rx_vote3 u_vote (
      .a_i   (s_a_q),
      .b_i   (s_b_q),
      .c_i   (line_i),
      .maj_o (vote),
      .dis_o (dis)
   );

   assign at_vote = (cnt_q == SMP2);
   assign at_last = (cnt_q == LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= RX_IDLE;
         cnt_q     <= '0;
         bit_idx_q <= '0;
         sh_q      <= '0;
         s_a_q     <= 1'b0;
         s_b_q     <= 1'b0;
         noise_q   <= 1'b0;
         par_bit_q <= 1'b0;
         last_q    <= 1'b1;
         done_o    <= 1'b0;
         data_o    <= '0;
         errs_o    <= '0;
      end else begin
         done_o <= 1'b0;
         if (halt_i) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
         end else if (tick_i) begin
            last_q <= line_i;
            if (state_q == RX_IDLE) begin
               if (last_q && !line_i) begin
                  state_q   <= RX_START;
                  cnt_q     <= CW'(1);
                  bit_idx_q <= '0;
                  noise_q   <= 1'b0;
               end
            end else begin
               cnt_q <= at_last ? '0 : cnt_q + 1'b1;
               if (cnt_q == SMP0) s_a_q <= line_i;
               if (cnt_q == SMP1) s_b_q <= line_i;
               if (at_vote) begin
                  unique case (state_q)
                     RX_START: begin
                        if (vote) state_q <= RX_IDLE;
                        else      noise_q <= dis;
                     end
                     RX_DATA: begin
                        sh_q    <= {vote, sh_q[DATA_BITS-1:1]};
                        noise_q <= noise_q | dis;
                     end
                     RX_PAR: begin
                        par_bit_q <= vote;
                        noise_q   <= noise_q | dis;
                     end
                     RX_STOP: begin
                        done_o       <= 1'b1;
                        data_o       <= sh_q;
                        errs_o.noise <= noise_q | dis;
                        errs_o.frame <= ~vote;
                        errs_o.par   <= par_en_i & (^sh_q ^ par_bit_q ^ par_odd_i);
                        state_q      <= RX_IDLE;
                     end
                     default: state_q <= RX_IDLE;
                  endcase
               end
               if (at_last) begin
                  unique case (state_q)
                     RX_START: state_q <= RX_DATA;
                     RX_DATA: begin
                        if (bit_idx_q == BIT_LAST) state_q <= par_en_i ? RX_PAR : RX_STOP;
                        else                       bit_idx_q <= bit_idx_q + 1'b1;
                     end
                     RX_PAR:  state_q <= RX_STOP;
                     default: ;
                  endcase
               end
            end
         end
      end
   end

   AST_STOP_FORCES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      halt_i |=> (state_q == RX_IDLE)); // R10
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R1
   AST_FALSE_START_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == RX_START && tick_i && !halt_i && at_vote && vote)
      |=> (state_q == RX_IDLE && !done_o)); // R2

endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
   import serial_rx_pkg::*;
#(
   parameter int unsigned DATA_BITS = 8
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 done_i,
   input  logic [DATA_BITS-1:0] data_i,
   input  frame_err_t           errs_i,
   input  logic                 stat_rd_i,
   input  logic                 data_rd_i,
   input  logic                 dbg_halt_i,
   input  logic                 clr_ok_i,
   input  logic [N_ERR-1:0]     ien_i,
   output logic [DATA_BITS-1:0] data_o,
   output logic [N_ERR-1:0]     flags_o,
   output logic                 full_o,
   output logic                 irq_o
);

   logic [DATA_BITS-1:0] data_q;
   logic [N_ERR-1:0]     flags_q, arm_q, new_set, clr_mask;
   logic                 full_q;
   logic                 clr_allow, rd_clr, accept, overrun;

   assign clr_allow = !dbg_halt_i || clr_ok_i;
   assign rd_clr    = data_rd_i && clr_allow;
   assign accept    = done_i && !full_q;
   assign overrun   = done_i && full_q;

   always_comb begin
      new_set = '0;
      if (accept) begin
         new_set[ERR_NOISE] = errs_i.noise;
         new_set[ERR_FRAME] = errs_i.frame;
         new_set[ERR_PAR]   = errs_i.par;
      end
      if (overrun) new_set[ERR_OVR] = 1'b1;
      clr_mask = rd_clr ? arm_q : '0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         data_q  <= '0;
         flags_q <= '0;
         arm_q   <= '0;
         full_q  <= 1'b0;
      end else begin
         flags_q <= (flags_q & ~clr_mask) | new_set;
         if (stat_rd_i)   arm_q <= flags_q;
         else if (rd_clr) arm_q <= '0;
         if (accept) begin
            data_q <= data_i;
            full_q <= 1'b1;
         end else if (rd_clr) begin
            full_q <= 1'b0;
         end
      end
   end

   assign data_o  = data_q;
   assign flags_o = flags_q;
   assign full_o  = full_q;
   assign irq_o   = |(flags_q & ien_i);

   AST_LOAD_SETS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept |=> (full_q && data_q == $past(data_i))); // R1
   AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
      overrun |=> ($stable(data_q) && full_q && flags_q[ERR_OVR])); // R6
   AST_HALT_BLOCKS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dbg_halt_i && !clr_ok_i)
      |=> ((($past(flags_q) & ~flags_q) == '0) && !($past(full_q) && !full_q))); // R9

endmodule

// File: rtl/serial_rx_errirq.sv
module serial_rx_errirq
   import serial_rx_pkg::*;
#(
   parameter int unsigned OSR         = 16,
   parameter int unsigned DATA_BITS   = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 rx_line_i,
   input  logic                 os_tick_i,
   input  logic                 rx_stop_i,
   input  logic                 par_en_i,
   input  logic                 par_odd_i,
   input  logic [N_ERR-1:0]     err_ien_i,
   input  logic                 stat_rd_i,
   input  logic                 data_rd_i,
   input  logic                 dbg_halt_i,
   input  logic                 halt_clr_ok_i,
   output logic [DATA_BITS-1:0] rx_data_o,
   output logic [N_ERR-1:0]     err_flags_o,
   output logic                 rx_full_o,
   output logic                 err_irq_o
);

   logic                 line_s;
   logic                 done;
   logic [DATA_BITS-1:0] char_data;
   frame_err_t           char_errs;

   rx_line_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (rx_line_i),
      .q_o    (line_s)
   );

   rx_bit_engine #(
      .OSR       (OSR),
      .DATA_BITS (DATA_BITS)
   ) u_engine (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .line_i    (line_s),
      .tick_i    (os_tick_i),
      .halt_i    (rx_stop_i),
      .par_en_i  (par_en_i),
      .par_odd_i (par_odd_i),
      .done_o    (done),
      .data_o    (char_data),
      .errs_o    (char_errs)
   );

   rx_status_regs #(
      .DATA_BITS (DATA_BITS)
   ) u_status (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .done_i     (done),
      .data_i     (char_data),
      .errs_i     (char_errs),
      .stat_rd_i  (stat_rd_i),
      .data_rd_i  (data_rd_i),
      .dbg_halt_i (dbg_halt_i),
      .clr_ok_i   (halt_clr_ok_i),
      .ien_i      (err_ien_i),
      .data_o     (rx_data_o),
      .flags_o    (err_flags_o),
      .full_o     (rx_full_o),
      .irq_o      (err_irq_o)
   );

endmodule

// File: tb/serial_rx_errirq_tb.sv
module serial_rx_errirq_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_line = 1'b1;
   logic       os_tick = 1'b0;
   logic       rx_stop = 1'b0;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic [3:0] ien = 4'h0;
   logic       stat_rd = 1'b0;
   logic       data_rd = 1'b0;
   logic       halt = 1'b0;
   logic       clr_ok = 1'b0;
   logic [7:0] rx_data;
   logic [3:0] flags;
   logic       full;
   logic       irq;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   // reference model state
   logic [7:0] m_data = 8'h00;
   logic [3:0] m_flags = 4'h0;
   logic [3:0] m_arm = 4'h0;
   logic       m_full = 1'b0;
   bit         pend = 0;
   logic [7:0] p_data;
   logic [3:0] p_err;

   always #5 clk = ~clk;

   serial_rx_errirq u_dut (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .rx_line_i     (rx_line),
      .os_tick_i     (os_tick),
      .rx_stop_i     (rx_stop),
      .par_en_i      (par_en),
      .par_odd_i     (par_odd),
      .err_ien_i     (ien),
      .stat_rd_i     (stat_rd),
      .data_rd_i     (data_rd),
      .dbg_halt_i    (halt),
      .halt_clr_ok_i (clr_ok),
      .rx_data_o     (rx_data),
      .err_flags_o   (flags),
      .rx_full_o     (full),
      .err_irq_o     (irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R1 data", 32'(rx_data), 32'(m_data));
      chk("R1/R8 full", 32'(full), 32'(m_full));
      chk("R6 overrun flag", 32'(flags[0]), 32'(m_flags[0]));
      chk("R3 noise flag", 32'(flags[1]), 32'(m_flags[1]));
      chk("R4 framing flag", 32'(flags[2]), 32'(m_flags[2]));
      chk("R5 parity flag", 32'(flags[3]), 32'(m_flags[3]));
      chk("R7 irq", 32'(irq), 32'(|(m_flags & ien)));
   endtask

   task automatic apply_commit();
      if (m_full) m_flags[0] = 1'b1;
      else begin
         m_data  = p_data;
         m_full  = 1'b1;
         m_flags = m_flags | p_err;
      end
   endtask

   // one clock step: compare at the falling edge, retire pending work, drop strobes
   task automatic cyc();
      @(negedge clk);
      if (rst_n) compare_all();
      if (pend) begin
         pend = 0;
         apply_commit();
      end
      os_tick = 1'b0;
      stat_rd = 1'b0;
      data_rd = 1'b0;
   endtask

   task automatic tick_bit(input logic lv, input bit commit);
      cyc();
      rx_line = lv;
      cyc();
      cyc();
      cyc();
      os_tick = 1'b1;
      if (commit) pend = 1;
   endtask

   task automatic idle_ticks(input int n);
      for (int i = 0; i < n; i++) tick_bit(1'b1, 0);
   endtask

   task automatic rd_status();
      cyc();
      stat_rd = 1'b1;
      m_arm = m_flags;
   endtask

   task automatic rd_data();
      cyc();
      data_rd = 1'b1;
      if (!(halt && !clr_ok)) begin
         m_flags = m_flags & ~m_arm;
         m_arm   = 4'h0;
         m_full  = 1'b0;
      end
   endtask

   task automatic rd_both();
      rd_status();
      rd_data();
      cyc();
   endtask

   // noise_bit: frame bit index (0 = start) whose centre sample is inverted, -1 for none
   task automatic send_frame(input logic [7:0] d, input logic pe, input logic odd,
                             input logic flip_par, input logic stop_v, input int noise_bit);
      int   nb;
      logic val;
      par_en  = pe;
      par_odd = odd;
      idle_ticks(2);
      nb = pe ? 11 : 10;
      p_data = d;
      p_err  = {pe & flip_par, ~stop_v, (noise_bit >= 0), 1'b0};
      for (int b = 0; b < nb; b++) begin
         if (b == 0)                 val = 1'b0;
         else if (b <= 8)            val = d[b-1];
         else if (pe && b == 9)      val = (^d) ^ odd ^ flip_par;
         else                        val = stop_v;
         for (int t = 0; t < 16; t++) begin
            if (b == nb - 1 && t > 9) break;
            tick_bit(val ^ ((b == noise_bit) && (t == 8)), (b == nb - 1) && (t == 9));
         end
      end
      idle_ticks(8);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      cyc();
      chk("R1 reset data", 32'(rx_data), 0);
      chk("R1 reset flags", 32'(flags), 0);
      chk("R1 reset full", 32'(full), 0);
      idle_ticks(4);

      // R1 plain frame
      send_frame(8'hA5, 0, 0, 0, 1, -1);
      chk("R1 char A5", 32'(rx_data), 32'hA5);
      chk("R1 full set", 32'(full), 1);
      rd_both();
      chk("R8 full cleared", 32'(full), 0);

      // R5 even parity good, then bad
      send_frame(8'h3C, 1, 0, 0, 1, -1);
      chk("R5 even ok", 32'(flags[3]), 0);
      rd_both();
      send_frame(8'h3C, 1, 0, 1, 1, -1);
      chk("R5 even bad", 32'(flags[3]), 1);
      chk("R7 irq masked", 32'(irq), 0);
      ien = 4'b1000;
      cyc();
      chk("R7 irq enabled", 32'(irq), 1);
      rd_both();
      chk("R8 parity cleared", 32'(flags), 0);
      send_frame(8'h81, 1, 1, 0, 1, -1);
      chk("R5 odd ok", 32'(flags[3]), 0);
      rd_both();
      send_frame(8'h80, 1, 1, 1, 1, -1);
      chk("R5 odd bad", 32'(flags[3]), 1);
      rd_both();

      // R3 noise on start, data and stop bits
      ien = 4'b0010;
      send_frame(8'h5A, 0, 0, 0, 1, 0);
      chk("R3 noise start", 32'(flags[1]), 1);
      chk("R3 data intact", 32'(rx_data), 32'h5A);
      rd_both();
      send_frame(8'h5A, 0, 0, 0, 1, 5);
      chk("R3 noise data", 32'(flags[1]), 1);
      rd_both();
      send_frame(8'hC3, 1, 0, 0, 1, 10);
      chk("R3 noise stop", 32'(flags[1]), 1);
      chk("R3 no frame err", 32'(flags[2]), 0);
      rd_both();

      // R4 framing and break
      send_frame(8'h55, 0, 0, 0, 0, -1);
      chk("R4 framing", 32'(flags[2]), 1);
      chk("R4 data kept", 32'(rx_data), 32'h55);
      rd_both();
      send_frame(8'h00, 0, 0, 0, 0, -1);
      chk("R4 break char", 32'(flags[2]), 1);
      rd_both();

      // R6 overrun keeps old character
      ien = 4'b0001;
      send_frame(8'h11, 0, 0, 0, 1, -1);
      send_frame(8'h22, 0, 0, 0, 0, 3);
      chk("R6 overrun", 32'(flags[0]), 1);
      chk("R6 old data", 32'(rx_data), 32'h11);
      chk("R6 lost errs dropped", 32'(flags[2:1]), 0);
      chk("R7 irq overrun", 32'(irq), 1);
      // R8 data read alone clears only full
      rd_data();
      cyc();
      chk("R8 full only", 32'(full), 0);
      chk("R8 flag stays", 32'(flags[0]), 1);
      rd_both();
      chk("R8 flag cleared", 32'(flags[0]), 0);

      // R9 debug halt blocks clearing
      send_frame(8'h66, 0, 0, 0, 0, -1);
      halt = 1'b1;
      clr_ok = 1'b0;
      rd_both();
      chk("R9 flag held", 32'(flags[2]), 1);
      chk("R9 full held", 32'(full), 1);
      clr_ok = 1'b1;
      rd_data();
      cyc();
      chk("R9 permitted clear", 32'(flags), 0);
      chk("R9 permitted full", 32'(full), 0);
      halt = 1'b0;
      clr_ok = 1'b0;

      // R2 false start: line low for ticks 0..6 only
      par_en = 1'b0;
      idle_ticks(2);
      for (int t = 0; t < 16; t++) tick_bit((t < 7) ? 1'b0 : 1'b1, 0);
      idle_ticks(170);
      chk("R2 no char", 32'(full), 0);
      chk("R2 no flags", 32'(flags), 0);
      send_frame(8'h9E, 0, 0, 0, 1, -1);
      chk("R2 next frame", 32'(rx_data), 32'h9E);
      rd_both();

      // R10 stop mid-frame
      idle_ticks(2);
      for (int t = 0; t < 16; t++) tick_bit(1'b0, 0);
      for (int t = 0; t < 48; t++) tick_bit(1'b1, 0);
      cyc();
      rx_stop = 1'b1;
      repeat (6) cyc();
      rx_stop = 1'b0;
      idle_ticks(200);
      chk("R10 abandoned", 32'(full), 0);
      chk("R10 no flags", 32'(flags), 0);
      send_frame(8'h47, 0, 0, 0, 1, -1);
      chk("R10 resumes", 32'(rx_data), 32'h47);
      chk("R10 resumes full", 32'(full), 1);
      rd_both();
      repeat (4) cyc();

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule